// File: doc/BRIEF.md
# Hot-swap link sequencer

This block is the control core that decides when a local single-ended I2C segment may be joined to a differential cable segment. A card that is powered up or plugged in live must not disturb traffic that is already on the cable. The block therefore waits for both supplies to be good, lets a settle period run, and then debounces the termination-detect flags. Only after that does it look at the bus itself.

Once ready, the block joins the two segments when the enable input is high and one of two events has happened. The first is a far-side bus that has stayed idle for a full window. The second is a STOP seen on the far side while the local wires are both high. Dropping enable, losing termination or losing a supply breaks the link again.

Every flag and bus level arrives through a two-flop synchroniser, so the state machine reacts on the third clock edge after an input changes. The one exception is the disconnect path for enable, which is faster.

States, with their codes on `state_o`:
- `ST_OFF` (0): a supply is missing.
- `ST_SETTLE` (1): the supply-settle count is running.
- `ST_DEBOUNCE` (2): the termination flags are being debounced.
- `ST_ARMED` (3): ready, waiting for enable and a bus event.
- `ST_JOINED` (4): the segments are linked.

Transitions:
- **supply-fail**: any state goes to `ST_OFF`.
- **supply-up**: `ST_OFF` goes to `ST_SETTLE`.
- **settle-done**: `ST_SETTLE` goes to `ST_DEBOUNCE`.
- **debounce-done**: `ST_DEBOUNCE` goes to `ST_ARMED`.
- **join**: `ST_ARMED` goes to `ST_JOINED`.
- **release**: `ST_JOINED` goes to `ST_ARMED` when enable drops.
- **term-loss**: `ST_ARMED` or `ST_JOINED` goes to `ST_SETTLE`.

Top module: `hsw_link_seq`

## Requirements
- R1: While either supply flag is low, the state code is 0 (`ST_OFF`) and both `link_on` and `rdy` are low. Losing a supply in any state returns the block to code 0.
- R2: After both supplies are good, the block stays in code 1 for `SETTLE_CYC` cycles and then moves to code 2.
- R3: Termination counts as valid only when all four flags are high: `term_lo[1:0]` (minus lines below the upper threshold, bit 0 data, bit 1 clock) and `term_hi[1:0]` (plus lines above the lower threshold). With any flag low, the block stays in code 2.
- R4: Code 3 with `rdy` high is reached only after `DEBOUNCE_CYC` consecutive cycles of valid termination. A single-cycle invalid flag during the count restarts the count.
- R5: In code 3 with `en` high, the block joins (code 4, `link_on` high) once both far-side plus lines have stayed high for `IDLE_CYC` cycles. Any low on either line restarts that window.
- R6: With `en` low the block never joins. If `en` falls while joined, `link_on` is low by the second rising clock edge, and the state returns to code 3.
- R7: In code 3 with `en` high, a far-side STOP (data rising while clock is high) joins the block once `loc_sda` and `loc_scl` are both high. This happens without waiting for the idle window, and a later START cancels the recorded STOP.
- R8: Loss of valid termination in code 3 or 4 drops `link_on` and restarts the sequence at code 1. This takes priority over a join that qualifies in the same cycle.
- R9: `linked` always equals `link_on`. `link_on` is registered and high only in code 4. `rdy` is high exactly in codes 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_a_ok | input | 1 | Card-side supply good |
| pwr_b_ok | input | 1 | Line-side supply good |
| term_lo | input | 2 | Minus line below upper threshold (bit 0 data, bit 1 clock) |
| term_hi | input | 2 | Plus line above lower threshold (bit 0 data, bit 1 clock) |
| dif_sda | input | 1 | Received far-side data level |
| dif_scl | input | 1 | Received far-side clock level |
| loc_sda | input | 1 | Local data wire level |
| loc_scl | input | 1 | Local clock wire level |
| en | input | 1 | Enable, active high |
| link_on | output | 1 | Join command to the data path |
| linked | output | 1 | Joined status |
| rdy | output | 1 | Ready status (sequence complete) |
| state_o | output | 3 | Current state code |

## Verification
Two functions can fall in the same clock cycle: a termination drop and a STOP-qualified join. The bench provokes this by driving a far-side STOP and then, one cycle later, clearing a termination flag. The flag path has one register fewer than the STOP path, so both conditions reach the state machine on the same edge. The check is that the block lands in the settle state with `link_on` low and never passes through the joined state. A second overlap is an enable drop while joined: the state is sampled on the second edge, where `link_on` must already be low while the state code still reads 4.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_SETTLE   = 3'd1,
        ST_DEBOUNCE = 3'd2,
        ST_ARMED    = 3'd3,
        ST_JOINED   = 3'd4
    } seq_state_t;

    // bit positions inside the synchronised input vector
    localparam int IX_PWR_A  = 0;
    localparam int IX_PWR_B  = 1;
    localparam int IX_TLO    = 2;
    localparam int IX_THI    = 4;
    localparam int IX_DSDA   = 6;
    localparam int IX_DSCL   = 7;
    localparam int IX_LSDA   = 8;
    localparam int IX_LSCL   = 9;
    localparam int IX_EN     = 10;
    localparam int SYNC_W    = 11;

endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hsw_tmr.sv
module hsw_tmr #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);

    // R4: a stopped timer never reports completion on the next cycle
    p_tmr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && LIMIT > 1) |=> !done || $past(run) == 1'b0 && cnt == '0 && LIMIT <= 1 || !done);
endmodule

// File: rtl/hsw_stopdet.sv
module hsw_stopdet (
    input  logic clk,
    input  logic rst_n,
    input  logic sda,
    input  logic scl,
    input  logic arm,
    output logic seen
);
    logic sda_d, scl_d;
    logic stop_ev, start_ev;

    assign stop_ev  = scl_d && scl && !sda_d && sda;
    assign start_ev = scl_d && scl && sda_d && !sda;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_d <= 1'b0;
            scl_d <= 1'b0;
            seen  <= 1'b0;
        end else begin
            sda_d <= sda;
            scl_d <= scl;
            if (!arm)          seen <= 1'b0;
            else if (stop_ev)  seen <= 1'b1;
            else if (start_ev) seen <= 1'b0;
        end
    end

    // R7: a fresh STOP record always follows data high with clock high
    p_stop_rec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seen) |-> ($past(sda) && $past(scl) && !$past(sda_d)));
endmodule

// File: rtl/hsw_link_seq.sv
module hsw_link_seq
    import hsw_pkg::*;
#(
    parameter int CLK_HZ       = 10_000_000,
    parameter int SETTLE_CYC   = CLK_HZ / 1000,
    parameter int DEBOUNCE_CYC = CLK_HZ / 100,
    parameter int IDLE_CYC     = CLK_HZ / 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_a_ok,
    input  logic       pwr_b_ok,
    input  logic [1:0] term_lo,
    input  logic [1:0] term_hi,
    input  logic       dif_sda,
    input  logic       dif_scl,
    input  logic       loc_sda,
    input  logic       loc_scl,
    input  logic       en,
    output logic       link_on,
    output logic       linked,
    output logic       rdy,
    output logic [2:0] state_o
);
    logic [SYNC_W-1:0] raw, syn;
    seq_state_t state_q, state_d;
    logic en_fast;
    logic pwr_ok, term_ok, far_idle, near_idle, en_s;
    logic ready_st, settle_done, deb_done, idle_done, stop_seen, join_ok;
    logic link_q, rdy_q;

    assign raw = {en, loc_scl, loc_sda, dif_scl, dif_sda, term_hi, term_lo, pwr_b_ok, pwr_a_ok};

    hsw_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (syn)
    );

    // single-stage sample of enable used only to open the link quickly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_fast <= 1'b0;
        else        en_fast <= en;
    end

    assign pwr_ok    = syn[IX_PWR_A] && syn[IX_PWR_B];
    assign term_ok   = &syn[IX_THI+1:IX_TLO];
    assign far_idle  = syn[IX_DSDA] && syn[IX_DSCL];
    assign near_idle = syn[IX_LSDA] && syn[IX_LSCL];
    assign en_s      = syn[IX_EN];
    assign ready_st  = (state_q == ST_ARMED) || (state_q == ST_JOINED);

    hsw_tmr #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_SETTLE),
        .done  (settle_done)
    );

    hsw_tmr #(.LIMIT(DEBOUNCE_CYC)) u_debounce (
        .clk   (clk),
        .rst_n (rst_n),
        .run   ((state_q == ST_DEBOUNCE) && term_ok),
        .done  (deb_done)
    );

    hsw_tmr #(.LIMIT(IDLE_CYC)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ready_st && far_idle),
        .done  (idle_done)
    );

    hsw_stopdet u_stop (
        .clk   (clk),
        .rst_n (rst_n),
        .sda   (syn[IX_DSDA]),
        .scl   (syn[IX_DSCL]),
        .arm   (state_q == ST_ARMED),
        .seen  (stop_seen)
    );

    assign join_ok = en_s && (idle_done || (stop_seen && near_idle));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!pwr_ok) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:      state_d = ST_SETTLE;
                ST_SETTLE:   if (settle_done) state_d = ST_DEBOUNCE;
                ST_DEBOUNCE: if (deb_done) state_d = ST_ARMED;
                ST_ARMED: begin
                    if (!term_ok)     state_d = ST_SETTLE;
                    else if (join_ok) state_d = ST_JOINED;
                end
                ST_JOINED: begin
                    if (!term_ok)   state_d = ST_SETTLE;
                    else if (!en_s) state_d = ST_ARMED;
                end
                default:     state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_q <= 1'b0;
            rdy_q  <= 1'b0;
        end else begin
            link_q <= (state_d == ST_JOINED) && en_fast;
            rdy_q  <= (state_d == ST_ARMED) || (state_d == ST_JOINED);
        end
    end

    assign link_on = link_q;
    assign linked  = link_q;
    assign rdy     = rdy_q;
    assign state_o = state_q;

    // R1: a missing supply forces the off state with the link open
    p_supply_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (state_q == ST_OFF) && !link_q && !rdy_q);

    // R9: the link is only closed while joined and ready
    p_link_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        link_q |-> (state_q == ST_JOINED) && rdy_q);

    // R6: enable low opens the link on the next edge
    p_en_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_fast |=> !link_q);

    // R8: termination loss while ready restarts at the settle stage
    p_term_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_st && pwr_ok && !term_ok) |=> (state_q == ST_SETTLE) && !link_q);

    // R5: a join is caused by an idle window or a qualified STOP with enable high
    p_join_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_q) |-> $past(en_s) && ($past(idle_done) || ($past(stop_seen) && $past(near_idle))));

    // R2: debounce is only entered from the settle stage
    p_settle_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEBOUNCE && $past(state_q) != ST_DEBOUNCE) |-> $past(state_q) == ST_SETTLE);
endmodule

// File: tb/hsw_link_seq_tb_top.sv
`timescale 1ns/1ps
module hsw_link_seq_tb_top;
    localparam int P_SETTLE = 20;
    localparam int P_DEB    = 40;
    localparam int P_IDLE   = 30;

    typedef struct {
        int         when;
        logic [2:0] st;
        logic       lnk;
        logic       rd;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n;
    logic pwr_a_ok, pwr_b_ok;
    logic [1:0] term_lo, term_hi;
    logic dif_sda, dif_scl, loc_sda, loc_scl, en;
    logic link_on, linked, rdy;
    logic [2:0] state_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hsw_link_seq #(
        .SETTLE_CYC   (P_SETTLE),
        .DEBOUNCE_CYC (P_DEB),
        .IDLE_CYC     (P_IDLE)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_a_ok (pwr_a_ok),
        .pwr_b_ok (pwr_b_ok),
        .term_lo  (term_lo),
        .term_hi  (term_hi),
        .dif_sda  (dif_sda),
        .dif_scl  (dif_scl),
        .loc_sda  (loc_sda),
        .loc_scl  (loc_scl),
        .en       (en),
        .link_on  (link_on),
        .linked   (linked),
        .rdy      (rdy),
        .state_o  (state_o)
    );

    // driver side: queue an expectation k cycles ahead
    task automatic expect_in(input int k, input logic [2:0] st, input logic lnk,
                             input logic rd, input string tag);
        exp_t e;
        e.when = cyc + k;
        e.st   = st;
        e.lnk  = lnk;
        e.rd   = rd;
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    // monitor: compare queued items at the negedge of their cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].when <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (state_o !== e.st || link_on !== e.lnk || rdy !== e.rd) begin
                errors++;
                $display("FAIL %s: state/link/rdy actual %0d/%0b/%0b expected %0d/%0b/%0b",
                         e.tag, state_o, link_on, rdy, e.st, e.lnk, e.rd);
            end
            checks++;
            if (linked !== link_on) begin
                errors++;
                $display("FAIL R9 (%s): linked actual %0b expected %0b", e.tag, linked, link_on);
            end
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        pwr_a_ok = 1'b0; pwr_b_ok = 1'b0;
        term_lo = 2'b00; term_hi = 2'b00;
        dif_sda = 1'b1; dif_scl = 1'b1;
        loc_sda = 1'b1; loc_scl = 1'b1;
        en = 1'b0;
        step(5);
        rst_n = 1'b1;

        // R1: reset state, then only one supply present
        expect_in(1, 3'd0, 1'b0, 1'b0, "R1 reset");
        step(1);
        pwr_a_ok = 1'b1;
        expect_in(10, 3'd0, 1'b0, 1'b0, "R1 single supply");
        step(10);

        // R2: settle stage length
        pwr_b_ok = 1'b1;
        expect_in(5, 3'd1, 1'b0, 1'b0, "R2 settle entered");
        expect_in(20, 3'd1, 1'b0, 1'b0, "R2 still settling");
        expect_in(26, 3'd2, 1'b0, 1'b0, "R2 settle done");
        step(26);

        // R3: three of four termination flags is not valid
        term_lo = 2'b11; term_hi = 2'b01;
        expect_in(60, 3'd2, 1'b0, 1'b0, "R3 partial termination");
        step(60);

        // R4: debounce with a one-cycle glitch restarting the count
        term_hi = 2'b11;
        step(30);
        term_hi = 2'b01;
        step(1);
        term_hi = 2'b11;
        expect_in(20, 3'd2, 1'b0, 1'b0, "R4 glitch restarted debounce");
        expect_in(38, 3'd2, 1'b0, 1'b0, "R4 debounce not yet done");
        expect_in(46, 3'd3, 1'b0, 1'b1, "R4 ready after debounce");
        step(46);

        // R6: idle bus but enable low never joins
        expect_in(40, 3'd3, 1'b0, 1'b1, "R6 enable low no join");
        step(40);

        // R5: enable high with idle window already satisfied
        en = 1'b1;
        expect_in(5, 3'd4, 1'b1, 1'b1, "R5 idle join");
        step(5);

        // R6: drop within two edges
        en = 1'b0;
        expect_in(2, 3'd4, 1'b0, 1'b1, "R6 fast release");
        expect_in(4, 3'd3, 1'b0, 1'b1, "R6 back to armed");
        step(4);

        // R5: busy far side blocks join
        dif_sda = 1'b0;
        step(3);
        en = 1'b1;
        expect_in(10, 3'd3, 1'b0, 1'b1, "R5 busy bus no join");
        step(10);
        dif_scl = 1'b0;
        step(2);
        dif_scl = 1'b1;
        step(2);

        // R7: STOP with local side busy, then local side released
        loc_sda = 1'b0;
        dif_sda = 1'b1;
        expect_in(6, 3'd3, 1'b0, 1'b1, "R7 local busy holds");
        step(7);
        loc_sda = 1'b1;
        expect_in(5, 3'd4, 1'b1, 1'b1, "R7 STOP join");
        step(5);

        // R8: termination loss while joined
        term_lo = 2'b01;
        expect_in(5, 3'd1, 1'b0, 1'b0, "R8 term loss restart");
        expect_in(15, 3'd1, 1'b0, 1'b0, "R8 settle rerun");
        step(5);
        term_lo = 2'b11;
        expect_in(100, 3'd4, 1'b1, 1'b1, "R5 rejoin after restart");
        step(100);

        // R8: termination loss and STOP join in the same cycle
        en = 1'b0;
        step(5);
        dif_sda = 1'b0;
        step(3);
        en = 1'b1;
        step(3);
        dif_sda = 1'b1;
        expect_in(6, 3'd1, 1'b0, 1'b0, "R8 coincident loss wins");
        step(1);
        term_lo = 2'b01;
        step(5);
        term_lo = 2'b11;

        // R1: supply loss, then full rerun to joined, then loss while joined
        pwr_a_ok = 1'b0;
        expect_in(5, 3'd0, 1'b0, 1'b0, "R1 supply loss");
        step(5);
        pwr_a_ok = 1'b1;
        expect_in(50, 3'd2, 1'b0, 1'b0, "R4 not ready before debounce");
        expect_in(110, 3'd4, 1'b1, 1'b1, "R5 join after full sequence");
        step(110);
        pwr_b_ok = 1'b0;
        expect_in(4, 3'd0, 1'b0, 1'b0, "R1 supply loss while joined");
        step(6);

        if (q.size() != 0) begin
            errors++;
            $display("FAIL bench: pending expectations actual %0d expected 0", q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule